// File: doc/BRIEF.md
# Configuration Register Target on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (I2C). A bus host uses it to reach a small bank of configuration bytes. The block samples the clock and data lines once per cycle of a fast system clock. Both lines must already be synchronized to that clock. The block drives the data line only through an open-drain enable, and it never drives the clock line.

Four of the seven address bits are fixed. The other three come from strap pins, so up to eight of these targets can share one bus. A write transfer has three parts: the address byte, one fill byte that is acknowledged and discarded, and then data bytes stored from register 0 upward. A read transfer returns bytes from register 0 upward. Every transfer starts again at register 0. The whole bank is always visible on a parallel output bus.

Top module: `cfg_i2c_target`

## Requirements
- R1: The target answers only to the 7-bit address {1, 1, strap[2], 0, 0, strap[1], strap[0]} (MSB first). After a START with any other address, it drives nothing and stores nothing until the next START.
- R2: The block acknowledges the address byte and every byte it receives. To do so, `sda_oe` rises after the SCL fall that ends the eighth bit and stays high until the SCL fall that ends the ninth bit.
- R3: The eighth bit of the address byte selects the direction: 1 is a read and 0 is a write.
- R4: In a write, the first byte after the address is acknowledged but not stored.
- R5: The write bytes after the fill byte go to registers 0, 1, 2 and so on, MSB first, on `cfg_bank[8*i+7:8*i]`. Every transfer restarts at register 0.
- R6: A read returns register 0, then 1 and so on, MSB first. `sda_oe` is 1 exactly for the 0 data bits.
- R7: The bank has 8 bytes. Write bytes beyond the eighth are acknowledged and dropped. Reads beyond the eighth byte return register 7 again.
- R8: After the host leaves a read byte unacknowledged, `sda_oe` stays 0 until the next START.
- R9: A STOP or a repeated START in the middle of a byte aborts the transfer, and the partial byte is not stored. After a repeated START, the block matches the address again.
- R10: `sda_oe` changes only while SCL is low. The block has no SCL output, so it cannot stall the host.
- R11: After reset, every configuration byte is 0x00 and `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line |
| strap | input | 3 | Address straps {bit4, bit1, bit0} |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| cfg_bank | output | 64 | Configuration bytes, register i at [8i+7:8i] |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- **Fill byte.** The bench writes a distinctive fill byte. A design that stores the fill byte moves every register by one place, and the per-clock bank comparison catches it at once.
- **Saturation.** The bench overruns the bank in both directions. An unchecked pointer would either corrupt a register or fail to acknowledge the extra byte. A wrapping pointer would return register 0 in place of register 7.
- **Aborted transfers.** The bench sends a STOP after three bits of a write byte. It also sends a repeated START in the middle of the fill-phase data, followed by a read. A design that keeps a partial byte changes register 1. A design that does not restart its pointer returns the wrong first byte.
- **NACK and address filtering.** The bench sends clock pulses after a NACK and uses an address whose strap bits do not match. Any acknowledge in these cases shows up at `sda_oe`.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_RECV,
        ST_SEND,
        ST_HACK
    } tgt_state_e;

    // Fixed address bits; strap pins fill positions 4, 1 and 0.
    localparam logic [6:0] ADDR_FIXED = 7'b1100000;

    function automatic logic [6:0] build_addr(input logic [2:0] strap);
        return {ADDR_FIXED[6:5], strap[2], ADDR_FIXED[3:2], strap[1], strap[0]};
    endfunction

endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    line_t q, d;

    always_comb begin
        d.scl = scl_i;
        d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign scl_rise  = scl_i & ~q.scl;
    assign scl_fall  = ~scl_i & q.scl;
    assign start_det = scl_i & q.scl & q.sda & ~sda_i;
    assign stop_det  = scl_i & q.scl & ~q.sda & sda_i;

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
    parameter int NUM_REGS = 8,
    parameter int PTR_W    = $clog2(NUM_REGS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [PTR_W-1:0]        waddr,
    input  logic [7:0]              wdata,
    output logic [NUM_REGS*8-1:0]   bank
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] byte_d, byte_q;

        always_comb begin
            byte_d = byte_q;
            if (we && (waddr == PTR_W'(g))) begin
                byte_d = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= 8'h00;
            end else begin
                byte_q <= byte_d;
            end
        end

        assign bank[g*8 +: 8] = byte_q;
    end

endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
    import cfg_i2c_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int PTR_W    = $clog2(NUM_REGS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sda_i,
    input  logic                    scl_rise,
    input  logic                    scl_fall,
    input  logic                    start_det,
    input  logic                    stop_det,
    input  logic [6:0]              tgt_addr,
    input  logic [NUM_REGS*8-1:0]   cfg_flat,
    output logic                    sda_oe,
    output logic                    bank_we,
    output logic [PTR_W-1:0]        bank_waddr,
    output logic [7:0]              bank_wdata
);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_REGS - 1);
    localparam logic [PTR_W-1:0] FULL_IDX = PTR_W'(NUM_REGS);

    typedef struct packed {
        tgt_state_e       st;
        logic [3:0]       cnt;
        logic [7:0]       sh;
        logic             rd;
        logic             fill;
        logic             nack;
        logic             oe;
        logic [PTR_W-1:0] ptr;
    } ctl_t;

    ctl_t q, d;

    logic [PTR_W-1:0] rd_idx_cur, rd_idx_nxt;
    logic [7:0]       rd_byte_cur, rd_byte_nxt;
    logic [7:0]       rx_byte;

    always_comb begin
        rd_idx_cur  = (q.ptr >= LAST_IDX) ? LAST_IDX : q.ptr;
        rd_idx_nxt  = (q.ptr >= LAST_IDX) ? LAST_IDX : q.ptr + 1'b1;
        rd_byte_cur = cfg_flat[32'(rd_idx_cur)*8 +: 8];
        rd_byte_nxt = cfg_flat[32'(rd_idx_nxt)*8 +: 8];
        rx_byte     = {q.sh[6:0], sda_i};
    end

    always_comb begin
        d          = q;
        bank_we    = 1'b0;
        bank_waddr = q.ptr;
        bank_wdata = rx_byte;

        if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_det) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
            d.ptr = '0;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    d.oe = 1'b0;
                end
                ST_ADDR: begin
                    if (scl_rise) begin
                        d.sh  = rx_byte;
                        d.cnt = q.cnt + 4'd1;
                        if (q.cnt == 4'd7) begin
                            if (q.sh[6:0] == tgt_addr) begin
                                d.st   = ST_ACK;
                                d.rd   = sda_i;
                                d.fill = ~sda_i;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (!q.oe) begin
                            d.oe = 1'b1;
                        end else begin
                            d.cnt = '0;
                            if (q.rd) begin
                                d.st = ST_SEND;
                                d.sh = rd_byte_cur;
                                d.oe = ~rd_byte_cur[7];
                            end else begin
                                d.st = ST_RECV;
                                d.oe = 1'b0;
                            end
                        end
                    end
                end
                ST_RECV: begin
                    if (scl_rise) begin
                        d.sh  = rx_byte;
                        d.cnt = q.cnt + 4'd1;
                        if (q.cnt == 4'd7) begin
                            d.st = ST_ACK;
                            if (q.fill) begin
                                d.fill = 1'b0;
                            end else if (q.ptr < FULL_IDX) begin
                                bank_we = 1'b1;
                                d.ptr   = q.ptr + 1'b1;
                            end
                        end
                    end
                end
                ST_SEND: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.oe = 1'b0;
                            d.st = ST_HACK;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b0};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                ST_HACK: begin
                    if (scl_rise) begin
                        d.nack = sda_i;
                    end else if (scl_fall) begin
                        if (q.nack) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.st  = ST_SEND;
                            d.cnt = '0;
                            d.ptr = rd_idx_nxt;
                            d.sh  = rd_byte_nxt;
                            d.oe  = ~rd_byte_nxt[7];
                        end
                    end
                end
                default: begin
                    d.st = ST_IDLE;
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, sh: '0, rd: 1'b0, fill: 1'b0,
                   nack: 1'b0, oe: 1'b0, ptr: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;

endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
    import cfg_i2c_pkg::*;
#(
    parameter int NUM_REGS = 8,
    localparam int PTR_W   = $clog2(NUM_REGS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    input  logic [2:0]              strap,
    output logic                    sda_oe,
    output logic [NUM_REGS*8-1:0]   cfg_bank
);
    logic             scl_rise, scl_fall, start_det, stop_det;
    logic             bank_we;
    logic [PTR_W-1:0] bank_waddr;
    logic [7:0]       bank_wdata;
    logic [6:0]       tgt_addr;

    assign tgt_addr = build_addr(strap);

    i2c_line_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_target_ctrl #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_i      (sda_i),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .tgt_addr   (tgt_addr),
        .cfg_flat   (cfg_bank),
        .sda_oe     (sda_oe),
        .bank_we    (bank_we),
        .bank_waddr (bank_waddr),
        .bank_wdata (bank_wdata)
    );

    cfg_reg_bank #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .waddr (bank_waddr),
        .wdata (bank_wdata),
        .bank  (cfg_bank)
    );

endmodule

// File: rtl/cfg_i2c_target_chk.sv
module cfg_i2c_target_chk #(
    parameter int NUM_REGS = 8,
    parameter int PTR_W    = $clog2(NUM_REGS + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    scl_i,
    input logic                    sda_oe,
    input logic                    start_det,
    input logic                    stop_det,
    input logic                    bank_we,
    input logic [PTR_W-1:0]        bank_waddr,
    input logic [NUM_REGS*8-1:0]   cfg_bank
);
    p_oe_moves_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    p_oe_holds_scl_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && scl_i && $past(scl_i)) |=> (sda_oe || !scl_i));

    p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    p_start_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    p_store_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |-> (bank_waddr < PTR_W'(NUM_REGS)));

    p_bank_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_we |=> $stable(cfg_bank));

    p_store_on_scl_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |-> scl_i);

endmodule

bind cfg_i2c_target cfg_i2c_target_chk #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_oe     (sda_oe),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .bank_we    (bank_we),
    .bank_waddr (bank_waddr),
    .cfg_bank   (cfg_bank)
);

// File: tb/sim_cfg_i2c_target.sv
`timescale 1ns/1ps
module sim_cfg_i2c_target;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl = 1'b1;
    logic         sda_h = 1'b1;
    logic [2:0]   strap = 3'b101;
    logic         sda_oe;
    logic [N*8-1:0] cfg_bank;
    logic         bus_sda;

    assign bus_sda = sda_h & ~sda_oe;

    always #4 clk = ~clk;

    cfg_i2c_target #(.NUM_REGS(N)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (bus_sda),
        .strap    (strap),
        .sda_oe   (sda_oe),
        .cfg_bank (cfg_bank)
    );

    int  n_checks = 0;
    int  n_fail   = 0;
    int  clk_fail_prints = 0;
    bit  chk_en = 1'b0;
    bit  done = 1'b0;
    logic [7:0] model_bank [N];
    logic       exp_oe = 1'b0;

    function automatic logic [N*8-1:0] model_flat();
        logic [N*8-1:0] f;
        for (int i = 0; i < N; i++) f[i*8 +: 8] = model_bank[i];
        return f;
    endfunction

    task automatic check_eq(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Per-clock reference comparison, sampled on the falling clock edge.
    always @(negedge clk) begin
        if (chk_en) begin
            n_checks += 2;
            if (sda_oe !== exp_oe) begin
                n_fail++;
                if (clk_fail_prints < 20)
                    $display("FAIL R2/R6/R10 sda_oe at %0t: actual %0b expected %0b", $time, sda_oe, exp_oe);
                clk_fail_prints++;
            end
            if (cfg_bank !== model_flat()) begin
                n_fail++;
                if (clk_fail_prints < 20)
                    $display("FAIL R4/R5/R7 cfg_bank at %0t: actual %0h expected %0h", $time, cfg_bank, model_flat());
                clk_fail_prints++;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic do_start();
        sda_h = 1'b1; tick(2);
        scl = 1'b1;   tick(2);
        sda_h = 1'b0; tick(2);
        scl = 1'b0;   tick(2);
    endtask

    task automatic do_stop();
        sda_h = 1'b0; tick(2);
        scl = 1'b1;   tick(2);
        sda_h = 1'b1; tick(3);
    endtask

    task automatic wr_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_h = b[i]; tick(2);
            scl = 1'b1;   tick(3);
            scl = 1'b0;   tick(2);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b, input bit exp_ack, input int store_idx,
                           input bit after_oe, input string tag);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; tick(2);
            scl = 1'b1;   tick(1);
            if (i == 0 && store_idx >= 0) model_bank[store_idx] = b;
            tick(2);
            scl = 1'b0;   tick(1);
            if (i == 0 && exp_ack) exp_oe = 1'b1;
            tick(1);
        end
        sda_h = 1'b1; tick(2);
        scl = 1'b1;   tick(2);
        check_eq(64'(bus_sda), 64'(!exp_ack), tag);
        tick(1);
        scl = 1'b0;   tick(1);
        exp_oe = exp_ack ? after_oe : 1'b0;
        tick(1);
    endtask

    task automatic rd_byte(input logic [7:0] b, input bit host_ack, input bit after_oe,
                           input string tag);
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            sda_h = 1'b1; tick(2);
            scl = 1'b1;   tick(2);
            got[i] = bus_sda;
            tick(1);
            scl = 1'b0;   tick(1);
            exp_oe = (i > 0) ? ~b[i-1] : 1'b0;
            tick(1);
        end
        check_eq(64'(got), 64'(b), tag);
        sda_h = ~host_ack; tick(2);
        scl = 1'b1;        tick(3);
        scl = 1'b0;        tick(1);
        exp_oe = host_ack ? after_oe : 1'b0;
        sda_h = 1'b1;
        tick(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] exp_rd [10];
        for (int i = 0; i < N; i++) model_bank[i] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R11: reset state
        check_eq(64'(cfg_bank), 64'h0, "R11 bank after reset");
        check_eq(64'(sda_oe), 64'h0, "R11 sda_oe after reset");
        chk_en = 1'b1;

        // Write with straps 101 -> address 0x71; fill byte 0x55 is discarded (R4)
        do_start();
        wr_byte(8'hE2, 1'b1, -1, 1'b0, "R1 R3 address ack write");
        wr_byte(8'h55, 1'b1, -1, 1'b0, "R4 fill byte ack");
        wr_byte(8'hA1, 1'b1, 0, 1'b0, "R5 data0 ack");
        wr_byte(8'h32, 1'b1, 1, 1'b0, "R5 data1 ack");
        wr_byte(8'hC3, 1'b1, 2, 1'b0, "R5 data2 ack");
        do_stop();
        check_eq(64'(cfg_bank[7:0]), 64'hA1, "R4 R5 reg0 holds first data byte");

        // Read back from register 0 (R3, R6), NACK ends it (R8)
        do_start();
        wr_byte(8'hE3, 1'b1, -1, ~model_bank[0][7], "R3 address ack read");
        rd_byte(8'hA1, 1'b1, ~model_bank[1][7], "R6 read reg0");
        rd_byte(8'h32, 1'b1, ~model_bank[2][7], "R6 read reg1");
        rd_byte(8'hC3, 1'b0, 1'b0, "R6 R8 read reg2 nack");
        // R8: clock pulses after NACK get no response
        wr_byte(8'h00, 1'b0, -1, 1'b0, "R8 no drive after nack");
        do_stop();

        // Wrong address for straps 101 (strap bit 4 mismatch) (R1)
        do_start();
        wr_byte(8'hC2, 1'b0, -1, 1'b0, "R1 foreign address no ack");
        wr_byte(8'h00, 1'b0, -1, 1'b0, "R1 idle after mismatch");
        wr_byte(8'hFF, 1'b0, -1, 1'b0, "R1 idle after mismatch 2");
        do_stop();

        // Straps 010 -> address 0x62; old address is now foreign (R1)
        strap = 3'b010;
        tick(2);
        do_start();
        wr_byte(8'hE2, 1'b0, -1, 1'b0, "R1 old address ignored");
        do_stop();

        // Overrun write: 9 data bytes, the last dropped but acked (R7)
        do_start();
        wr_byte(8'hC4, 1'b1, -1, 1'b0, "R1 strap 010 address ack");
        wr_byte(8'h00, 1'b1, -1, 1'b0, "R4 fill byte zero ack");
        for (int i = 0; i < N; i++)
            wr_byte(8'h10 + 8'(i) + 8'(i << 4), 1'b1, i, 1'b0, "R5 sequential store");
        wr_byte(8'hEE, 1'b1, -1, 1'b0, "R7 overrun ack dropped");
        do_stop();
        check_eq(64'(cfg_bank[63:56]), 64'h87, "R7 last reg not overwritten");

        // Overrun read: 10 bytes, last two repeat reg 7 (R7)
        for (int i = 0; i < 10; i++) exp_rd[i] = model_bank[(i < N) ? i : N - 1];
        do_start();
        wr_byte(8'hC5, 1'b1, -1, ~exp_rd[0][7], "R3 read address ack");
        for (int i = 0; i < 10; i++)
            rd_byte(exp_rd[i], (i < 9), (i < 9) ? ~exp_rd[(i < 9) ? i + 1 : i][7] : 1'b0,
                    (i < N) ? "R6 read sequence" : "R7 read saturates at reg7");
        do_stop();

        // STOP in mid-byte aborts; partial byte not stored (R9)
        do_start();
        wr_byte(8'hC4, 1'b1, -1, 1'b0, "R9 address ack");
        wr_byte(8'h5A, 1'b1, -1, 1'b0, "R4 fill ack");
        wr_byte(8'h99, 1'b1, 0, 1'b0, "R5 restart at reg0");
        wr_bits(8'h00, 3);
        do_stop();
        check_eq(64'(cfg_bank[15:8]), 64'(model_bank[1]), "R9 partial byte not stored");

        // Repeated START in mid-byte, then read from reg0 (R9, R5)
        do_start();
        wr_byte(8'hC4, 1'b1, -1, 1'b0, "R9 address ack 2");
        wr_byte(8'h5A, 1'b1, -1, 1'b0, "R4 fill ack 2");
        wr_bits(8'hFF, 4);
        do_start();
        wr_byte(8'hC5, 1'b1, -1, ~model_bank[0][7], "R9 rematch after repeated start");
        rd_byte(8'h99, 1'b0, 1'b0, "R5 R9 read restarts at reg0");
        do_stop();
        check_eq(64'(cfg_bank), 64'(model_flat()), "R9 bank after aborts");

        tick(4);
        chk_en = 1'b0;
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule